// File: doc/BRIEF.md
# Four-Input Sum-of-Products Event Logic Cell

This cell builds one Boolean function from on-chip event signals such as PWM edges, comparator outputs, timer outputs and pin levels. A routing crossbar picks four of the incoming event sources, labelled A, B, C and D. Each of four product terms ANDs together every one of those four picks. In a term, each pick can appear true or complemented, or can force the term to 0 or leave it unaffected. The four terms are ORed, optionally inverted, and drive a single output. That output can gate or derive a synchronous-rectifier drive from a PWM and a zero-cross comparator, or carry a trigger from one block to another.

A small write port sets the crossbar selects, the four term codes and an output-control word. Each configuration register takes its first write after reset and then locks. Later writes to it, and writes to unmapped addresses, leave all contents as they were and raise an error flag for one cycle. A control bit chooses between a purely combinational output and an output re-timed by one register stage.

Top module: `evt_logic_cell`

## Requirements
- R1: Address 0 holds the crossbar selects, with pick A in bits [SEL_W-1:0], B in the next SEL_W bits, then C, then D. Each pick follows source `src_i[sel]` for its own select value.
- R2: Addresses 1 to 4 hold the codes of product terms 0 to 3, with pick A in bits [1:0], B in [3:2], C in [5:4] and D in [7:6]. A code of 00 forces the term to 0, 01 uses the pick true, 10 uses it complemented, and 11 leaves the term unaffected by that pick.
- R3: Before inversion the output is the OR of the four product terms. Bit 0 of the control word at address 5 inverts it.
- R4: Bit 1 of the control word at address 5 selects the registered output, which shows the function one clock after its inputs change. With the bit clear, `evt_o` follows the inputs in the same cycle.
- R5: Each of the six registers accepts only its first write after reset. Later writes to it leave the output function unchanged.
- R6: A write to a locked register, or to address 6 or 7, drives `cfg_err_o` high for exactly the one cycle after the write. A write that is accepted leaves it low.
- R7: Reset sets every term code to 00, every select to 0 and both control bits to 0, so `evt_o` is 0. It also releases every lock.
- R8: With pick A on a PWM source and pick B on a zero-cross source, term code 8'hF9 gives a rectifier gate that is high only while the PWM is high and the zero-cross is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Event sources offered to the crossbar |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration register address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_err_o | output | 1 | Rejected-write flag, one cycle after the write |
| evt_o | output | 1 | Function output |

## Verification
On every cycle the assertions check the lock and error behaviour. The error flag only follows a write and always follows a rejected one. Locks never clear while out of reset, and a rejected write leaves the selects, the codes and the output mode untouched. They also check that reset leaves everything cleared and unlocked, and that the registered output equals the combinational value from one cycle earlier. Only the bench scenarios can show that each 2-bit code has its stated meaning, that the crossbar routes the right source into each pick, that the OR and the inversion give the full truth tables, and that the PWM and zero-cross gate comes out right.

// File: rtl/evt_logic_pkg.sv
package evt_logic_pkg;

    localparam int NUM_IN    = 4;
    localparam int NUM_TERM  = 4;
    localparam int CODE_W    = 2 * NUM_IN;

    localparam int ADDR_SEL   = 0;
    localparam int ADDR_TERM0 = 1;
    localparam int ADDR_CTRL  = ADDR_TERM0 + NUM_TERM;
    localparam int NUM_REGS   = ADDR_CTRL + 1;

    typedef enum logic [1:0] {
        LIT_ZERO = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_ONE  = 2'b11
    } lit_e;

    typedef logic [CODE_W-1:0] term_code_t;

endpackage

// File: rtl/evt_xbar.sv
module evt_xbar
    import evt_logic_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int SEL_W = 4
) (
    input  logic [N_SRC-1:0]        src_i,
    input  logic [NUM_IN*SEL_W-1:0] sel_i,
    output logic [NUM_IN-1:0]       pick_o
);

    localparam int SPAN = 2 ** SEL_W;

    logic [SPAN-1:0] src_wide;
    assign src_wide = SPAN'(src_i);

    for (genvar k = 0; k < NUM_IN; k++) begin : g_pick
        assign pick_o[k] = src_wide[sel_i[k*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/evt_term.sv
module evt_term
    import evt_logic_pkg::*;
(
    input  logic [NUM_IN-1:0] pick_i,
    input  term_code_t        code_i,
    output logic              hit_o
);

    always_comb begin
        hit_o = 1'b1;
        for (int k = 0; k < NUM_IN; k++) begin
            case (lit_e'(code_i[2*k +: 2]))
                LIT_ZERO: hit_o = 1'b0;
                LIT_TRUE: hit_o = hit_o & pick_i[k];
                LIT_COMP: hit_o = hit_o & ~pick_i[k];
                LIT_ONE:  hit_o = hit_o;
                default:  hit_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evt_cfg.sv
module evt_cfg
    import evt_logic_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int ADDR_W = 3,
    parameter int CFG_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [CFG_W-1:0]            wdata_i,
    output logic [NUM_IN*SEL_W-1:0]     sel_o,
    output term_code_t [NUM_TERM-1:0]   code_o,
    output logic                        inv_o,
    output logic                        regout_o,
    output logic [NUM_REGS-1:0]         lock_o,
    output logic                        err_o
);

    localparam int SELS_W = NUM_IN * SEL_W;

    typedef struct packed {
        logic [SELS_W-1:0]          sel;
        term_code_t [NUM_TERM-1:0]  code;
        logic                       inv;
        logic                       regout;
        logic [NUM_REGS-1:0]        lock;
        logic                       err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_REGS-1:0] hit_dec;

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            hit_dec[r] = (addr_i == ADDR_W'(r));
        end
    end

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.err = 1'b0;
        if (we_i) begin
            if (hit_dec == '0 || (hit_dec & cfg_q.lock) != '0) begin
                cfg_d.err = 1'b1;
            end else begin
                cfg_d.lock = cfg_q.lock | hit_dec;
                if (hit_dec[ADDR_SEL]) begin
                    cfg_d.sel = wdata_i[SELS_W-1:0];
                end
                for (int t = 0; t < NUM_TERM; t++) begin
                    if (hit_dec[ADDR_TERM0 + t]) begin
                        cfg_d.code[t] = wdata_i[CODE_W-1:0];
                    end
                end
                if (hit_dec[ADDR_CTRL]) begin
                    cfg_d.inv    = wdata_i[0];
                    cfg_d.regout = wdata_i[1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_o    = cfg_q.sel;
    assign code_o   = cfg_q.code;
    assign inv_o    = cfg_q.inv;
    assign regout_o = cfg_q.regout;
    assign lock_o   = cfg_q.lock;
    assign err_o    = cfg_q.err;

endmodule

// File: rtl/evt_logic_cell.sv
module evt_logic_cell
    import evt_logic_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 3,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CFG_W = (NUM_IN * SEL_W > CODE_W) ? NUM_IN * SEL_W : CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              cfg_err_o,
    output logic              evt_o
);

    typedef struct packed {
        logic val;
    } out_t;

    logic [NUM_IN*SEL_W-1:0]    sel;
    term_code_t [NUM_TERM-1:0]  codes;
    logic                       inv;
    logic                       regout;
    logic [NUM_REGS-1:0]        lock;
    logic [NUM_IN-1:0]          pick;
    logic [NUM_TERM-1:0]        hits;
    logic                       comb_val;
    out_t                       out_d, out_q;

    evt_cfg #(
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .sel_o    (sel),
        .code_o   (codes),
        .inv_o    (inv),
        .regout_o (regout),
        .lock_o   (lock),
        .err_o    (cfg_err_o)
    );

    evt_xbar #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) u_xbar (
        .src_i  (src_i),
        .sel_i  (sel),
        .pick_o (pick)
    );

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        evt_term u_term (
            .pick_i (pick),
            .code_i (codes[t]),
            .hit_o  (hits[t])
        );
    end

    assign comb_val = (|hits) ^ inv;

    always_comb begin
        out_d     = out_q;
        out_d.val = comb_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign evt_o = regout ? out_q.val : comb_val;

endmodule

// File: rtl/evt_logic_cell_chk.sv
module evt_logic_cell_chk
    import evt_logic_pkg::*;
#(
    parameter int SELS_W = 16,
    parameter int ADDR_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we_i,
    input logic [ADDR_W-1:0]         cfg_addr_i,
    input logic                      cfg_err_o,
    input logic                      evt_o,
    input logic [NUM_REGS-1:0]       lock,
    input logic [NUM_TERM*CODE_W-1:0] codes,
    input logic [SELS_W-1:0]         sel,
    input logic                      inv,
    input logic                      regout,
    input logic                      comb_val
);

    localparam int LW = 2 ** ADDR_W;

    logic [LW-1:0] lock_wide;
    logic          reject;
    assign lock_wide = LW'(lock);
    assign reject    = cfg_we_i &&
                       ((cfg_addr_i >= ADDR_W'(NUM_REGS)) || lock_wide[cfg_addr_i]);

    p_err_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(cfg_we_i));

    p_err_on_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> cfg_err_o);

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|lock) |=> ((lock & $past(lock)) == $past(lock)));

    p_locked_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(codes) && $stable(sel) && $stable(inv) && $stable(regout)));

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lock == '0 && codes == '0 && sel == '0 && !inv && !regout && !evt_o));

    p_regout_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regout && $past(regout)) |-> (evt_o == $past(comb_val)));

endmodule

bind evt_logic_cell evt_logic_cell_chk #(
    .SELS_W (NUM_IN * SEL_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_err_o  (cfg_err_o),
    .evt_o      (evt_o),
    .lock       (lock),
    .codes      (codes),
    .sel        (sel),
    .inv        (inv),
    .regout     (regout),
    .comb_val   (comb_val)
);

// File: tb/evt_logic_cell_test.sv
module evt_logic_cell_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src;
    logic        we;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic        err;
    logic        evt;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_sel  [4];
    logic [7:0] m_code [4];
    logic       m_inv;

    always #10 clk = ~clk;

    evt_logic_cell #(.N_SRC(16), .ADDR_W(3)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_err_o   (err),
        .evt_o       (evt)
    );

    function automatic logic model(input logic [15:0] s);
        logic any = 1'b0;
        for (int t = 0; t < 4; t++) begin
            logic hit = 1'b1;
            for (int k = 0; k < 4; k++) begin
                logic lit = s[m_sel[k]];
                case (m_code[t][2*k +: 2])
                    2'b00: hit = 1'b0;
                    2'b01: hit = hit & lit;
                    2'b10: hit = hit & ~lit;
                    default: hit = hit;
                endcase
            end
            any = any | hit;
        end
        return any ^ m_inv;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        src   = '0;
        m_inv = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_sel[i]  = '0;
            m_code[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d,
                      input logic exp_err, input string req);
        @(negedge clk);
        we    = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        we = 1'b0;
        #1 check(req, err, exp_err);
    endtask

    task automatic drive(input logic [15:0] s, input string req);
        @(negedge clk);
        src = s;
        #1 check(req, evt, model(s));
    endtask

    task automatic set_identity();
        wr(3'd0, 16'h3210, 1'b0, "R5 first sel write accepted");
        m_sel[0] = 4'd0; m_sel[1] = 4'd1; m_sel[2] = 4'd2; m_sel[3] = 4'd3;
    endtask

    task automatic t_reset();
        do_reset();
        src = 16'hFFFF;
        #1 check("R7 output zero after reset", evt, 1'b0);
        check("R7 no error after reset", err, 1'b0);
    endtask

    task automatic t_xbar();
        do_reset();
        wr(3'd0, 16'hF095, 1'b0, "R1 sel write");
        m_sel[0] = 4'd5; m_sel[1] = 4'd9; m_sel[2] = 4'd0; m_sel[3] = 4'd15;
        wr(3'd1, 16'h00FD, 1'b0, "R1 term0"); m_code[0] = 8'hFD;
        wr(3'd2, 16'h00F7, 1'b0, "R1 term1"); m_code[1] = 8'hF7;
        wr(3'd3, 16'h00DF, 1'b0, "R1 term2"); m_code[2] = 8'hDF;
        wr(3'd4, 16'h007F, 1'b0, "R1 term3"); m_code[3] = 8'h7F;
        for (int i = 0; i < 16; i++) begin
            drive(16'(1 << i), "R1 single source");
        end
        drive(16'h0000, "R1 no source");
        drive(16'h7DDE, "R1 unselected sources only");
    endtask

    task automatic t_codes();
        do_reset();
        set_identity();
        wr(3'd1, 16'h00F9, 1'b0, "R2 term0"); m_code[0] = 8'hF9;
        wr(3'd2, 16'h00FC, 1'b0, "R2 term1"); m_code[1] = 8'hFC;
        for (int i = 0; i < 16; i++) begin
            drive({12'hABC, 4'(i)}, "R2 code truth table");
        end
    endtask

    task automatic t_sum_invert();
        do_reset();
        set_identity();
        wr(3'd1, 16'h00F5, 1'b0, "R3 term0"); m_code[0] = 8'hF5;
        wr(3'd2, 16'h005F, 1'b0, "R3 term1"); m_code[1] = 8'h5F;
        wr(3'd5, 16'h0001, 1'b0, "R3 ctrl");  m_inv = 1'b1;
        for (int i = 0; i < 16; i++) begin
            drive({12'h000, 4'(i)}, "R3 inverted sum");
        end
    endtask

    task automatic t_regout();
        do_reset();
        set_identity();
        wr(3'd1, 16'h00FD, 1'b0, "R4 term0");
        wr(3'd5, 16'h0002, 1'b0, "R4 ctrl");
        @(negedge clk);
        src = 16'h0001;
        #1 check("R4 registered output holds before edge", evt, 1'b0);
        @(negedge clk);
        #1 check("R4 registered output after edge", evt, 1'b1);
        src = 16'h0000;
        #1 check("R4 registered output holds on fall", evt, 1'b1);
        @(negedge clk);
        #1 check("R4 registered output falls after edge", evt, 1'b0);
    endtask

    task automatic t_lock();
        do_reset();
        set_identity();
        wr(3'd1, 16'h00FD, 1'b0, "R5 first term0 write"); m_code[0] = 8'hFD;
        wr(3'd1, 16'h0000, 1'b1, "R6 locked term write flagged");
        @(negedge clk);
        #1 check("R6 error lasts one cycle", err, 1'b0);
        drive(16'h0001, "R5 term0 unchanged after rejected write");
        wr(3'd0, 16'h0001, 1'b1, "R6 locked sel write flagged");
        drive(16'h0002, "R5 sel unchanged after rejected write");
        drive(16'h0001, "R5 sel unchanged after rejected write");
        wr(3'd6, 16'h0003, 1'b1, "R6 unmapped address 6 flagged");
        wr(3'd7, 16'h0003, 1'b1, "R6 unmapped address 7 flagged");
        drive(16'h0001, "R5 unmapped writes change nothing");
        wr(3'd5, 16'h0001, 1'b0, "R5 first ctrl write"); m_inv = 1'b1;
        drive(16'h0001, "R3 invert after ctrl write");
        wr(3'd5, 16'h0000, 1'b1, "R6 locked ctrl write flagged");
        drive(16'h0000, "R5 ctrl unchanged after rejected write");
    endtask

    task automatic t_relock();
        do_reset();
        wr(3'd1, 16'h00FD, 1'b0, "R7 lock released by reset"); m_code[0] = 8'hFD;
        drive(16'h0001, "R7 selects cleared to source 0");
        drive(16'hFFFE, "R7 selects cleared to source 0");
    endtask

    task automatic t_rectifier();
        do_reset();
        wr(3'd0, 16'h0073, 1'b0, "R8 sel pwm and zero-cross");
        m_sel[0] = 4'd3; m_sel[1] = 4'd7;
        wr(3'd1, 16'h00F9, 1'b0, "R8 gate code"); m_code[0] = 8'hF9;
        @(negedge clk); src = 16'h0008; #1 check("R8 pwm high zc low", evt, 1'b1);
        @(negedge clk); src = 16'h0088; #1 check("R8 pwm high zc high", evt, 1'b0);
        @(negedge clk); src = 16'h0080; #1 check("R8 pwm low zc high", evt, 1'b0);
        @(negedge clk); src = 16'hFF77; #1 check("R8 pwm low zc low", evt, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_xbar();
        t_codes();
        t_sum_invert();
        t_regout();
        t_lock();
        t_relock();
        t_rectifier();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule